// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single line. It uses a one-cycle tick pulse at sixteen times the bit rate. A falling edge that is still low at mid-bit starts a frame. Each data bit is sampled once, near the centre of its bit period, and data arrives least significant bit first. Parity is optional. A finished character is placed into a receive data register, and the block raises a data-available flag.

Four error and event conditions are kept as sticky flags in a status word:

- a parity mismatch;
- a missing stop bit (framing error);
- a character that completes while the previous one is still unread (overrun);
- a break, meaning a line held low for a whole character.

One interrupt line covers all of these. The data-available part of the interrupt has its own enable; the error and break parts are always active. A read strobe on the data register clears data-available. A read strobe on the status word clears the error and break flags. After a break, and after a framing error, the receiver waits for the line to go high again before it looks for another start bit.

Top module: `uart_rx_brk`

## Requirements
- R1: A start bit is accepted only if the synchronised line is still low at the mid-bit tick. A low pulse shorter than half a bit produces no character and no flag.
- R2: Data bits are taken least significant bit first. When the stop bit has been sampled, the character is in `rx_data` and `rx_stat[0]` (data available) reads 1.
- R3: A pulse on `rd_data` clears `rx_stat[0]` by the following cycle, unless a character completes in that same cycle.
- R4: If a character completes while `rx_stat[0]` is still 1, `rx_stat[1]` (overrun) is set. `rx_data` keeps the earlier character and the new one is discarded.
- R5: With `par_en`=1, one parity bit follows the data. `par_odd`=0 selects even parity (the XOR of the data and parity bits is 0) and `par_odd`=1 selects odd parity. A mismatch sets `rx_stat[2]`.
- R6: A stop bit sampled as 0 sets `rx_stat[3]` (framing error) when the character is not a break. The character is still stored.
- R7: If every data bit, the parity bit (when enabled) and the stop bit are 0, the result is a break. `rx_stat[4]` is set, while `rx_stat[0]`, `rx_stat[3]` and `rx_data` are left unchanged.
- R8: After a break, no start bit is recognised until the line has returned high. The next character after the line goes high is received normally.
- R9: A pulse on `rd_stat` clears `rx_stat[4:1]`.
- R10: `irq` is 1 exactly when `rx_stat[4:1]` is non-zero, or when `rx_stat[0]` and `data_ie` are both 1. With `data_ie`=0, data-available alone does not raise `irq`.
- R11: After reset, `rx_data`, `rx_stat` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high, asynchronous to clk |
| tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| par_en | input | 1 | Parity bit present, latched at frame start |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data_ie | input | 1 | Enable for the data-available interrupt |
| rd_data | input | 1 | Read strobe for the receive data register |
| rd_stat | input | 1 | Read strobe for the status word |
| rx_data | output | DATA_W | Receive data register |
| rx_stat | output | 5 | {break, framing, parity, overrun, data available} |
| irq | output | 1 | Combined receiver interrupt |

## Verification
The hardest situation to reach is the period after a break. The line is still low and the break flag has already been cleared by a status read, yet no new frame may start. The stimulus holds the line low for a full character with parity enabled, then reads the status word while the line is still low. It then keeps the line low for many more bit times and confirms that the status stays clear. Finally it releases the line and sends a character, which must be received normally. Overrun is reached by leaving a character unread while a second one arrives. A glitch shorter than half a bit exercises the mid-bit start check.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   localparam int STAT_W = 5;
   localparam int ST_AVL = 0;
   localparam int ST_OVR = 1;
   localparam int ST_PAR = 2;
   localparam int ST_FRM = 3;
   localparam int ST_BRK = 4;

   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4,
      RX_HOLD  = 3'd5
   } rx_state_e;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rx_flags_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   initial begin
      if (STAGES < 0 || STAGES > 4) $error("uart_rx_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} >> 0;
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done_o,
   output logic [DATA_W-1:0] done_data,
   output rx_flags_t         done_flags
);

   localparam int CW = $clog2(OVS);
   localparam int IW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);
   localparam logic [IW-1:0] TOPB = IW'(DATA_W - 1);

   initial begin
      if (OVS < 4 || (OVS % 2) != 0) $error("uart_rx_framer: OVS must be even and >= 4");
      if (DATA_W < 5 || DATA_W > 9)  $error("uart_rx_framer: DATA_W must be 5..9");
   end

   rx_state_e         st_q;
   logic [CW-1:0]     cnt_q;
   logic [IW-1:0]     idx_q;
   logic [DATA_W-1:0] sh_q;
   logic              pb_q;
   logic              pe_q;
   logic              po_q;

   logic all_zero;
   logic is_brk;
   logic par_bad;

   always_comb begin
      all_zero = (sh_q == '0) && (!pe_q || !pb_q);
      is_brk   = !rx_s && all_zero;
      par_bad  = pe_q && ((^sh_q ^ pb_q) != po_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= RX_IDLE;
         cnt_q      <= '0;
         idx_q      <= '0;
         sh_q       <= '0;
         pb_q       <= 1'b0;
         pe_q       <= 1'b0;
         po_q       <= 1'b0;
         done_o     <= 1'b0;
         done_data  <= '0;
         done_flags <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            RX_IDLE: begin
               if (tick && !rx_s) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
                  pe_q  <= par_en;
                  po_q  <= par_odd;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt_q == MID) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     st_q  <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (cnt_q == LAST) begin
                     cnt_q <= '0;
                     sh_q  <= {rx_s, sh_q[DATA_W-1:1]};
                     if (idx_q == TOPB) st_q <= pe_q ? RX_PAR : RX_STOP;
                     else               idx_q <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_PAR: begin
               if (tick) begin
                  if (cnt_q == LAST) begin
                     cnt_q <= '0;
                     pb_q  <= rx_s;
                     st_q  <= RX_STOP;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (cnt_q == LAST) begin
                     cnt_q           <= '0;
                     done_o          <= 1'b1;
                     done_data       <= sh_q;
                     done_flags.brk  <= is_brk;
                     done_flags.ferr <= !rx_s && !is_brk;
                     done_flags.perr <= par_bad && !is_brk;
                     st_q            <= rx_s ? RX_IDLE : RX_HOLD;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            RX_HOLD: begin
               if (rx_s) st_q <= RX_IDLE;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   // R8: while held after a break, no character may complete
   p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_HOLD && $past(st_q) == RX_HOLD) |-> !done_o);

   // R7: a break result always carries an all-zero character
   p_brk_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && done_flags.brk) |-> (done_data == '0 && !done_flags.ferr));

   // R1: an aborted start returns to idle without producing a result
   p_start_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RX_START && tick && cnt_q == MID && rx_s) |=> (st_q == RX_IDLE && !done_o));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] done_data,
   input  rx_flags_t         done_flags,
   input  logic              rd_data,
   input  logic              rd_stat,
   input  logic              data_ie,
   output logic [DATA_W-1:0] rx_data,
   output logic [STAT_W-1:0] rx_stat,
   output logic              irq
);

   logic avl_q, ovr_q, par_q, frm_q, brk_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avl_q  <= 1'b0;
         ovr_q  <= 1'b0;
         par_q  <= 1'b0;
         frm_q  <= 1'b0;
         brk_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (rd_data) avl_q <= 1'b0;
         if (rd_stat) begin
            ovr_q <= 1'b0;
            par_q <= 1'b0;
            frm_q <= 1'b0;
            brk_q <= 1'b0;
         end
         if (done) begin
            if (done_flags.brk) begin
               brk_q <= 1'b1;
            end else if (avl_q && !rd_data) begin
               ovr_q <= 1'b1;
            end else begin
               data_q <= done_data;
               avl_q  <= 1'b1;
               if (done_flags.perr) par_q <= 1'b1;
               if (done_flags.ferr) frm_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rx_data            = data_q;
      rx_stat            = '0;
      rx_stat[ST_AVL]    = avl_q;
      rx_stat[ST_OVR]    = ovr_q;
      rx_stat[ST_PAR]    = par_q;
      rx_stat[ST_FRM]    = frm_q;
      rx_stat[ST_BRK]    = brk_q;
      irq = (avl_q && data_ie) || ovr_q || par_q || frm_q || brk_q;
   end

   // R4: the overrun event never disturbs the held character
   p_ovr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $stable(data_q));

   // R3: a data read with no arriving character clears availability
   p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !done) |=> !avl_q);

   // R9: a status read with no arriving result clears every error flag
   p_st_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !done) |=> !(ovr_q || par_q || frm_q || brk_q));

   // R7: a break leaves the data register untouched
   p_brk_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_flags.brk) |=> $stable(data_q));

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
   import uart_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd,
   input  logic              tick,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              data_ie,
   input  logic              rd_data,
   input  logic              rd_stat,
   output logic [DATA_W-1:0] rx_data,
   output logic [4:0]        rx_stat,
   output logic              irq
);

   logic              rx_s;
   logic              done;
   logic [DATA_W-1:0] done_data;
   rx_flags_t         done_flags;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rxd),
      .dout  (rx_s)
   );

   uart_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rx_s       (rx_s),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .done_o     (done),
      .done_data  (done_data),
      .done_flags (done_flags)
   );

   uart_rx_status #(.DATA_W(DATA_W)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .done_data  (done_data),
      .done_flags (done_flags),
      .rd_data    (rd_data),
      .rd_stat    (rd_stat),
      .data_ie    (data_ie),
      .rx_data    (rx_data),
      .rx_stat    (rx_stat),
      .irq        (irq)
   );

   // R10: an empty status word never raises the interrupt
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stat == 5'd0) |-> !irq);

   // R10: error and break flags raise the interrupt regardless of data_ie
   p_err_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stat[4:1] != 4'd0) |-> irq);

endmodule

// File: tb/sim_uart_rx_brk.sv
module sim_uart_rx_brk;

   localparam int BITC = 64;   // 16 ticks x 4 clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rxd = 1'b1;
   logic tick = 1'b0;
   logic par_en = 1'b0, par_odd = 1'b0, data_ie = 1'b1;
   logic rd_data = 1'b0, rd_stat = 1'b0;
   logic [7:0] rx_data;
   logic [4:0] rx_stat;
   logic irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [1:0] tdiv = 2'd0;

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) begin
      tdiv <= tdiv + 2'd1;
      tick <= (tdiv == 2'd3);
   end

   uart_rx_brk u0 (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick),
      .par_en(par_en), .par_odd(par_odd), .data_ie(data_ie),
      .rd_data(rd_data), .rd_stat(rd_stat),
      .rx_data(rx_data), .rx_stat(rx_stat), .irq(irq)
   );

   typedef struct packed {
      logic [7:0] d;
      logic [4:0] s;
      logic       i;
   } exp_t;

   exp_t  exq[$];
   string tgq[$];
   event  ev_chk;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end

   // monitor: pops expectations and compares with the outputs
   initial begin
      forever begin
         @(ev_chk);
         @(negedge clk);
         while (exq.size() > 0) begin
            exp_t  e;
            string t;
            e = exq.pop_front();
            t = tgq.pop_front();
            checks = checks + 1;
            if (rx_data !== e.d || rx_stat !== e.s || irq !== e.i) begin
               errors = errors + 1;
               $display("FAIL %s: actual data=%h stat=%b irq=%b expected data=%h stat=%b irq=%b",
                        t, rx_data, rx_stat, irq, e.d, e.s, e.i);
            end
         end
      end
   end

   task automatic expect_now(input logic [7:0] d, input logic [4:0] s, input logic i, input string t);
      exp_t e;
      e.d = d; e.s = s; e.i = i;
      exq.push_back(e);
      tgq.push_back(t);
      -> ev_chk;
      wait (exq.size() == 0);
      @(posedge clk);
   endtask

   task automatic hold_line(input logic b, input int nbits);
      rxd = b;
      repeat (nbits * BITC) @(posedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic use_par, input logic pb, input logic stopb);
      hold_line(1'b0, 1);
      for (int k = 0; k < 8; k++) hold_line(d[k], 1);
      if (use_par) hold_line(pb, 1);
      hold_line(stopb, 1);
      rxd = 1'b1;
      repeat (8) @(posedge clk);
   endtask

   task automatic pulse_rd_data();
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
   endtask

   task automatic pulse_rd_stat();
      @(negedge clk); rd_stat = 1'b1;
      @(negedge clk); rd_stat = 1'b0;
   endtask

   initial begin
      repeat (5) @(posedge clk);
      expect_now(8'h00, 5'b00000, 1'b0, "R11 reset");
      rst_n = 1'b1;
      hold_line(1'b1, 2);
      expect_now(8'h00, 5'b00000, 1'b0, "R11 idle after reset");

      // R2 basic character, R10 data interrupt enabled
      send(8'hA5, 1'b0, 1'b0, 1'b1);
      expect_now(8'hA5, 5'b00001, 1'b1, "R2 char A5");
      data_ie = 1'b0;
      @(posedge clk);
      expect_now(8'hA5, 5'b00001, 1'b0, "R10 data irq masked");
      pulse_rd_data();
      expect_now(8'hA5, 5'b00000, 1'b0, "R3 data read clears avail");
      data_ie = 1'b1;

      // R1 short glitch
      rxd = 1'b0;
      repeat (12) @(posedge clk);
      hold_line(1'b1, 3);
      expect_now(8'hA5, 5'b00000, 1'b0, "R1 glitch ignored");

      // R4 overrun
      send(8'h3C, 1'b0, 1'b0, 1'b1);
      send(8'hC3, 1'b0, 1'b0, 1'b1);
      expect_now(8'h3C, 5'b00011, 1'b1, "R4 overrun keeps first");
      pulse_rd_stat();
      expect_now(8'h3C, 5'b00001, 1'b1, "R9 status read clears overrun");
      pulse_rd_data();

      // R5 parity
      par_en = 1'b1;
      send(8'h07, 1'b1, 1'b1, 1'b1);
      expect_now(8'h07, 5'b00001, 1'b1, "R5 even parity good");
      pulse_rd_data();
      send(8'h07, 1'b1, 1'b0, 1'b1);
      expect_now(8'h07, 5'b00101, 1'b1, "R5 even parity bad");
      pulse_rd_stat();
      pulse_rd_data();
      par_odd = 1'b1;
      send(8'h07, 1'b1, 1'b0, 1'b1);
      expect_now(8'h07, 5'b00001, 1'b1, "R5 odd parity good");
      pulse_rd_data();
      par_odd = 1'b0;

      // R6 framing
      par_en = 1'b0;
      send(8'h81, 1'b0, 1'b0, 1'b0);
      expect_now(8'h81, 5'b01001, 1'b1, "R6 framing error");
      pulse_rd_stat();
      pulse_rd_data();
      expect_now(8'h81, 5'b00000, 1'b0, "R9 status read clears framing");

      // R7 break with parity enabled, data irq masked
      par_en  = 1'b1;
      data_ie = 1'b0;
      hold_line(1'b0, 11);
      expect_now(8'h81, 5'b10000, 1'b1, "R7 break flagged");
      pulse_rd_stat();
      hold_line(1'b0, 20);
      expect_now(8'h81, 5'b00000, 1'b0, "R8 no start while line low");
      hold_line(1'b1, 2);
      data_ie = 1'b1;
      send(8'h5A, 1'b1, 1'b0, 1'b1);
      expect_now(8'h5A, 5'b00001, 1'b1, "R8 char after break");
      pulse_rd_data();
      expect_now(8'h5A, 5'b00000, 1'b0, "R3 final read");

      summary();
   end

endmodule